// File: doc/BRIEF.md
# IN Endpoint Bank Handshake Controller

This block tracks who owns each data bank of one device-side bulk or interrupt IN endpoint, which may use one bank or two. Firmware fills the bank it currently points at and then releases it to the hardware with a strobe. The hardware answers each host IN token from the oldest released bank. If no bank is released, it answers with NAK. When the host's ACK arrives, the bank goes back to firmware.

Two flags show the state of the bank firmware points at. The bank flag tells whether that bank belongs to firmware. The ready flag is a sticky notice that a bank has just become free, and it drives the endpoint interrupt when the interrupt is enabled. Releasing a bank clears the bank flag and, in two-bank mode, moves the firmware pointer on. Both flags are then worked out again from the newly selected bank. The token side uses one-cycle strobes: token in, ACK received and timeout in; send DATA (with its bank number) or send NAK out.

Top module: `inep_ctrl`

## Requirements
- R1: After reset, both banks belong to firmware, `sw_bank` is 0, `txrdy` and `bankctl` are 1, `int_en` is 0, and neither `send_data` nor `send_nak` is asserted.
- R2: `ep_irq` is 1 exactly when `txrdy` and `int_en` are both 1. `sw_ien_set` sets `int_en` and `sw_ien_clr` clears it. If both are asserted in the same cycle, the clear wins.
- R3: `sw_txrdy_clr` clears `txrdy` in the next cycle. It leaves `bank_hw`, `bankctl` and `sw_bank` unchanged. If a ready event happens in the same cycle, the ready event wins.
- R4: `sw_bank_rel` with `bankctl`=1 sets `bank_hw[sw_bank]` in the next cycle. With `cfg_multi`=1, `sw_bank` advances modulo 2. With `cfg_multi`=0, `sw_bank` stays 0.
- R5: When the bank at `sw_bank` becomes firmware-owned, `txrdy` and `bankctl` are both 1 in the next cycle. This happens after a release that selects a free bank, and after an ACK that frees the selected bank.
- R6: `sw_bank_rel` while `bankctl`=0 has no effect on `bank_hw` or `sw_bank`.
- R7: `tok_in` produces exactly one response in the next cycle. The response is `send_data` if the bank at the hardware pointer is released, and `send_nak` otherwise.
- R8: `ack_rx` after a DATA response frees the transmitted bank (its `bank_hw` bit becomes 0) and advances the hardware pointer. `ack_rx` with no DATA response outstanding has no effect.
- R9: After `tok_timeout`, the transmitted bank stays released. The next `tok_in` sends DATA from the same bank again.
- R10: Banks are transmitted in release order. `tx_bank` gives the bank of each DATA response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_multi | input | 1 | 1 = two banks, 0 = one bank; change only during reset |
| sw_txrdy_clr | input | 1 | Firmware strobe: clear the ready flag |
| sw_bank_rel | input | 1 | Firmware strobe: release the current bank |
| sw_ien_set | input | 1 | Firmware strobe: set the interrupt enable |
| sw_ien_clr | input | 1 | Firmware strobe: clear the interrupt enable |
| tok_in | input | 1 | Host IN token received |
| ack_rx | input | 1 | Host ACK received |
| tok_timeout | input | 1 | No ACK arrived for the last DATA |
| txrdy | output | 1 | Ready flag |
| bankctl | output | 1 | Current firmware bank is owned by firmware |
| int_en | output | 1 | Interrupt enable |
| ep_irq | output | 1 | Endpoint interrupt |
| sw_bank | output | 1 | Firmware bank pointer |
| bank_hw | output | 2 | Per-bank hardware ownership |
| send_data | output | 1 | Send DATA from `tx_bank` |
| send_nak | output | 1 | Send NAK |
| tx_bank | output | 1 | Bank of the current DATA response |

## Verification
The assertions assume that `cfg_multi` changes only while reset is held. They also assume `ack_rx` and `tok_timeout` come only after a DATA response, never together and never in the same cycle as `tok_in`. The random stimulus follows these rules by tracking whether a DATA response is outstanding in the bench model. It raises the ACK and timeout strobes only in that case and keeps them apart from tokens. The bank count is changed only under reset. Firmware strobes are random and unrestricted, so releases and ready-flag clears also arrive in the illegal states and get tested there.

// File: rtl/inep_pkg.sv
package inep_pkg;
  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_DATA = 2'd1,
    RSP_NAK  = 2'd2
  } rsp_e;
endpackage

// File: rtl/inep_rst_sync.sv
module inep_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/inep_ptr_step.sv
module inep_ptr_step #(
  parameter int MAX_BANKS = 2,
  parameter int PW        = 1
) (
  input  logic [PW-1:0] cur,
  input  logic          cfg_multi,
  input  logic          adv,
  output logic [PW-1:0] nxt
);
  localparam logic [PW-1:0] TOP_IDX = PW'(MAX_BANKS - 1);

  logic [PW-1:0] last_idx;

  always_comb begin
    last_idx = cfg_multi ? TOP_IDX : '0;
    if (!adv)                nxt = cur;
    else if (cur >= last_idx) nxt = '0;
    else                      nxt = cur + PW'(1);
  end
endmodule

// File: rtl/inep_bank_owner.sv
module inep_bank_owner
  import inep_pkg::*;
#(
  parameter int MAX_BANKS = 2,
  parameter int PW        = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_multi,
  input  logic                 tok_in,
  input  logic                 ack_rx,
  input  logic                 tok_timeout,
  input  logic                 rel_ok,
  input  logic [PW-1:0]        sw_ptr,
  output logic [MAX_BANKS-1:0] own_q,
  output logic [MAX_BANKS-1:0] own_d,
  output rsp_e                 rsp_q,
  output logic [PW-1:0]        rsp_bank_q
);
  logic [PW-1:0] hw_ptr_q, hw_ptr_d;
  logic          inflight_q, inflight_d;
  logic          ack_ok, hw_ready;
  rsp_e          rsp_d;
  logic [PW-1:0] rsp_bank_d;
  logic          rsp_bank_en;

  assign ack_ok   = ack_rx & inflight_q;
  assign hw_ready = own_q[hw_ptr_q];

  inep_ptr_step #(.MAX_BANKS(MAX_BANKS), .PW(PW)) u_hw_step (
    .cur       (hw_ptr_q),
    .cfg_multi (cfg_multi),
    .adv       (ack_ok),
    .nxt       (hw_ptr_d)
  );

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    logic bank_en;
    always_comb begin
      own_d[b] = own_q[b];
      if (ack_ok && (hw_ptr_q == PW'(b))) own_d[b] = 1'b0;
      if (rel_ok && (sw_ptr   == PW'(b))) own_d[b] = 1'b1;
      bank_en  = own_d[b] ^ own_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       own_q[b] <= 1'b0;
      else if (bank_en) own_q[b] <= own_d[b];
    end
  end

  always_comb begin
    if (tok_in && hw_ready)          inflight_d = 1'b1;
    else if (ack_rx || tok_timeout)  inflight_d = 1'b0;
    else                             inflight_d = inflight_q;

    if (!tok_in)       rsp_d = RSP_NONE;
    else if (hw_ready) rsp_d = RSP_DATA;
    else               rsp_d = RSP_NAK;

    rsp_bank_en = tok_in & hw_ready;
    rsp_bank_d  = hw_ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_ptr_q   <= '0;
      inflight_q <= 1'b0;
      rsp_q      <= RSP_NONE;
    end else begin
      if (ack_ok) hw_ptr_q <= hw_ptr_d;
      inflight_q <= inflight_d;
      rsp_q      <= rsp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rsp_bank_q <= '0;
    else if (rsp_bank_en) rsp_bank_q <= rsp_bank_d;
  end
endmodule

// File: rtl/inep_flag_unit.sv
module inep_flag_unit #(
  parameter int MAX_BANKS = 2,
  parameter int PW        = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_multi,
  input  logic                 rel_req,
  input  logic                 txrdy_clr,
  input  logic                 ien_set,
  input  logic                 ien_clr,
  input  logic [MAX_BANKS-1:0] own_d,
  output logic                 rel_ok,
  output logic [PW-1:0]        sw_ptr_q,
  output logic                 txrdy_q,
  output logic                 bankctl_q,
  output logic                 int_en_q
);
  logic [PW-1:0] sw_ptr_d;
  logic          bankctl_d, txrdy_d, int_en_d;
  logic          ready_evt;

  assign rel_ok = rel_req & bankctl_q;

  inep_ptr_step #(.MAX_BANKS(MAX_BANKS), .PW(PW)) u_sw_step (
    .cur       (sw_ptr_q),
    .cfg_multi (cfg_multi),
    .adv       (rel_ok),
    .nxt       (sw_ptr_d)
  );

  always_comb begin
    bankctl_d = ~own_d[sw_ptr_d];
    ready_evt = bankctl_d & (~bankctl_q | rel_ok);
    if (ready_evt)      txrdy_d = 1'b1;
    else if (txrdy_clr) txrdy_d = 1'b0;
    else                txrdy_d = txrdy_q;
    if (ien_clr)        int_en_d = 1'b0;
    else if (ien_set)   int_en_d = 1'b1;
    else                int_en_d = int_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_ptr_q  <= '0;
      bankctl_q <= 1'b1;
      txrdy_q   <= 1'b1;
      int_en_q  <= 1'b0;
    end else begin
      if (rel_ok)                  sw_ptr_q <= sw_ptr_d;
      bankctl_q <= bankctl_d;
      if (ready_evt || txrdy_clr)  txrdy_q  <= txrdy_d;
      if (ien_set || ien_clr)      int_en_q <= int_en_d;
    end
  end
endmodule

// File: rtl/inep_ctrl.sv
module inep_ctrl
  import inep_pkg::*;
#(
  parameter int MAX_BANKS = 2,
  localparam int PW       = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_multi,
  input  logic                 sw_txrdy_clr,
  input  logic                 sw_bank_rel,
  input  logic                 sw_ien_set,
  input  logic                 sw_ien_clr,
  input  logic                 tok_in,
  input  logic                 ack_rx,
  input  logic                 tok_timeout,
  output logic                 txrdy,
  output logic                 bankctl,
  output logic                 int_en,
  output logic                 ep_irq,
  output logic [PW-1:0]        sw_bank,
  output logic [MAX_BANKS-1:0] bank_hw,
  output logic                 send_data,
  output logic                 send_nak,
  output logic [PW-1:0]        tx_bank
);
  logic                 rst_sync_n;
  logic                 rel_ok;
  logic [MAX_BANKS-1:0] own_d;
  rsp_e                 rsp_q;

  inep_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  inep_bank_owner #(.MAX_BANKS(MAX_BANKS), .PW(PW)) u_owner (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_multi   (cfg_multi),
    .tok_in      (tok_in),
    .ack_rx      (ack_rx),
    .tok_timeout (tok_timeout),
    .rel_ok      (rel_ok),
    .sw_ptr      (sw_bank),
    .own_q       (bank_hw),
    .own_d       (own_d),
    .rsp_q       (rsp_q),
    .rsp_bank_q  (tx_bank)
  );

  inep_flag_unit #(.MAX_BANKS(MAX_BANKS), .PW(PW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_multi (cfg_multi),
    .rel_req   (sw_bank_rel),
    .txrdy_clr (sw_txrdy_clr),
    .ien_set   (sw_ien_set),
    .ien_clr   (sw_ien_clr),
    .own_d     (own_d),
    .rel_ok    (rel_ok),
    .sw_ptr_q  (sw_bank),
    .txrdy_q   (txrdy),
    .bankctl_q (bankctl),
    .int_en_q  (int_en)
  );

  assign send_data = (rsp_q == RSP_DATA);
  assign send_nak  = (rsp_q == RSP_NAK);
  assign ep_irq    = txrdy & int_en;
endmodule

// File: rtl/inep_ctrl_chk.sv
module inep_ctrl_chk #(
  parameter int MAX_BANKS = 2,
  parameter int PW        = 1
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 cfg_multi,
  input logic                 sw_txrdy_clr,
  input logic                 sw_bank_rel,
  input logic                 ack_rx,
  input logic                 tok_in,
  input logic                 txrdy,
  input logic                 bankctl,
  input logic                 int_en,
  input logic                 ep_irq,
  input logic [PW-1:0]        sw_bank,
  input logic [MAX_BANKS-1:0] bank_hw,
  input logic                 send_data,
  input logic                 send_nak
);
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(send_data && send_nak)); // R7
  AST_RESPONSE_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (send_data || send_nak) |-> $past(tok_in)); // R7
  AST_NAK_WHEN_NONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tok_in && bank_hw == '0) |=> send_nak); // R7
  AST_FLAGS_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bankctl) |-> txrdy); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ep_irq |-> (txrdy && int_en)); // R2
  AST_CLEAR_KEEPS_BANKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sw_txrdy_clr && !sw_bank_rel && !ack_rx) |=> ($stable(bank_hw) && $stable(bankctl))); // R3
  AST_STALE_RELEASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sw_bank_rel && !bankctl && !ack_rx) |=> ($stable(sw_bank) && $stable(bank_hw))); // R6
  AST_SINGLE_BANK_POINTER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_multi |-> (sw_bank == '0)); // R4
endmodule

bind inep_ctrl inep_ctrl_chk #(.MAX_BANKS(MAX_BANKS), .PW(PW)) u_chk (.*);

// File: tb/tb_inep_ctrl.sv
module tb_inep_ctrl;
  logic clk, rst_n, cfg_multi;
  logic sw_txrdy_clr, sw_bank_rel, sw_ien_set, sw_ien_clr;
  logic tok_in, ack_rx, tok_timeout;
  logic txrdy, bankctl, int_en, ep_irq, send_data, send_nak;
  logic [0:0] sw_bank, tx_bank;
  logic [1:0] bank_hw;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model state
  logic [1:0] m_own;
  logic m_sp, m_hp, m_inf, m_tr, m_bc, m_ie, m_sd, m_sn, m_tb;

  inep_ctrl dut (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic inc(input logic p);
    return (cfg_multi && p == 1'b0) ? 1'b1 : 1'b0;
  endfunction

  task automatic model_reset();
    m_own = 2'b00; m_sp = 0; m_hp = 0; m_inf = 0;
    m_tr = 1; m_bc = 1; m_ie = 0; m_sd = 0; m_sn = 0; m_tb = 0;
  endtask

  task automatic model_step(input logic tk, ak, to, rl, cl, is, ic);
    logic [1:0] own_n; logic ack_ok, rel_ok, sp_n, bc_n, evt;
    ack_ok = ak & m_inf;
    rel_ok = rl & m_bc;
    own_n = m_own;
    if (ack_ok) own_n[m_hp] = 1'b0;
    if (rel_ok) own_n[m_sp] = 1'b1;
    sp_n = rel_ok ? inc(m_sp) : m_sp;
    bc_n = ~own_n[sp_n];
    evt  = bc_n & (~m_bc | rel_ok);
    m_sd = tk & m_own[m_hp];
    m_sn = tk & ~m_own[m_hp];
    if (m_sd) m_tb = m_hp;
    if (tk && m_own[m_hp]) m_inf = 1;
    else if (ak || to)     m_inf = 0;
    if (ack_ok) m_hp = inc(m_hp);
    m_tr  = evt ? 1'b1 : (cl ? 1'b0 : m_tr);
    m_ie  = ic ? 1'b0 : (is ? 1'b1 : m_ie);
    m_own = own_n; m_sp = sp_n; m_bc = bc_n;
  endtask

  task automatic cmp_all();
    chk(8'(txrdy),     8'(m_tr),         "R3 txrdy");
    chk(8'(bankctl),   8'(m_bc),         "R5 bankctl");
    chk(8'(int_en),    8'(m_ie),         "R2 int_en");
    chk(8'(ep_irq),    8'(m_tr & m_ie),  "R2 ep_irq");
    chk(8'(sw_bank),   8'(m_sp),         "R4 sw_bank");
    chk(8'(bank_hw),   8'(m_own),        "R8 bank_hw");
    chk(8'(send_data), 8'(m_sd),         "R7 send_data");
    chk(8'(send_nak),  8'(m_sn),         "R7 send_nak");
    if (m_sd) chk(8'(tx_bank), 8'(m_tb), "R10 tx_bank");
  endtask

  // called at a negedge; returns at the next negedge with inputs idle
  task automatic cyc(input logic tk, ak, to, rl, cl, is, ic);
    tok_in = tk; ack_rx = ak; tok_timeout = to; sw_bank_rel = rl;
    sw_txrdy_clr = cl; sw_ien_set = is; sw_ien_clr = ic;
    @(posedge clk);
    model_step(tk, ak, to, rl, cl, is, ic);
    @(negedge clk);
    {tok_in, ack_rx, tok_timeout, sw_bank_rel, sw_txrdy_clr, sw_ien_set, sw_ien_clr} = '0;
    cmp_all();
  endtask

  task automatic do_reset(input logic multi);
    rst_n = 0;
    {tok_in, ack_rx, tok_timeout, sw_bank_rel, sw_txrdy_clr, sw_ien_set, sw_ien_clr} = '0;
    cfg_multi = multi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(1'b1);
    // R1 reset state
    chk(8'(bank_hw), 8'h0, "R1 bank_hw");
    chk(8'(sw_bank), 8'h0, "R1 sw_bank");
    chk(8'({txrdy, bankctl, int_en}), 8'b110, "R1 flags");
    chk(8'({send_data, send_nak}), 8'h0, "R1 responses");
    // R7 token with nothing released -> NAK
    cyc(1,0,0,0,0,0,0);
    chk(8'(send_nak), 8'h1, "R7 nak when empty");
    // R2 enable; set+clear together, clear wins
    cyc(0,0,0,0,0,1,0);
    chk(8'(ep_irq), 8'h1, "R2 irq raised");
    cyc(0,0,0,0,0,1,1);
    chk(8'(int_en), 8'h0, "R2 clear wins");
    // R3 clear of ready flag keeps banks
    cyc(0,0,0,0,1,0,0);
    chk(8'({txrdy, bankctl, bank_hw}), 8'b0100, "R3 clear only flag");
    // R4/R5 release bank 0, bank 1 free -> both flags set
    cyc(0,0,0,1,0,0,0);
    chk(8'({txrdy, bankctl, sw_bank, bank_hw}), 8'b11101, "R5 next free bank");
    cyc(0,0,0,0,1,0,0);
    cyc(0,0,0,1,0,0,0);
    chk(8'({bankctl, sw_bank, bank_hw}), 8'b0011, "R4 both released");
    // R6 release while bank owned by hardware
    cyc(0,0,0,1,0,0,0);
    chk(8'({sw_bank, bank_hw}), 8'b011, "R6 ignored release");
    // R8 ack without outstanding data ignored
    cyc(0,1,0,0,0,0,0);
    chk(8'(bank_hw), 8'b11, "R8 stray ack");
    // R10/R9 data, timeout, resend
    cyc(1,0,0,0,0,0,0);
    chk(8'({send_data, tx_bank}), 8'b10, "R10 first bank");
    cyc(0,0,1,0,0,0,0);
    cyc(1,0,0,0,0,0,0);
    chk(8'({send_data, tx_bank, bank_hw}), 8'b1011, "R9 resend");
    cyc(0,1,0,0,0,0,0);
    chk(8'({txrdy, bankctl, bank_hw}), 8'b1110, "R5 ack frees selected bank");
    cyc(1,0,0,0,0,0,0);
    chk(8'({send_data, tx_bank}), 8'b11, "R10 second bank");
    cyc(0,1,0,0,0,0,0);
    chk(8'(bank_hw), 8'b00, "R8 freed");

    // single-bank mode
    do_reset(1'b0);
    cyc(0,0,0,0,1,0,0);
    cyc(0,0,0,1,0,0,0);
    chk(8'({txrdy, bankctl, sw_bank, bank_hw}), 8'b00001, "R4 single bank");
    cyc(1,0,0,0,0,0,0);
    cyc(0,1,0,0,0,0,0);
    chk(8'({txrdy, bankctl, bank_hw}), 8'b1100, "R5 single bank freed");

    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      do_reset(ph[0]);
      for (int n = 0; n < 3000; n++) begin
        logic tk, ak, to;
        tk = 0; ak = 0; to = 0;
        if (m_inf && ($urandom % 3 == 0)) begin
          if ($urandom % 4 == 0) to = 1; else ak = 1;
        end else begin
          tk = ($urandom % 4 == 0);
        end
        cyc(tk, ak, to, ($urandom % 3 == 0), ($urandom % 4 == 0),
            ($urandom % 8 == 0), ($urandom % 10 == 0));
      end
    end
    finish_run();
  end
endmodule